// File: doc/BRIEF.md
# Framed Serial Link Transmitter

This block sends a parallel data word over a point-to-point serial link. It runs on the serial bit clock. It splits that clock into frames of `DATA_W + 4` bit times, and every frame boundary acts as one edge of the parallel clock. At each such edge it takes a new word from `din`. In the frame that follows, it sends a leading zero guard bit, the word least significant bit first, two overhead ones that hold the line steady, and a closing zero.

A level input controls power. While that input is low, the serial driver is disabled. When it goes high, the block waits for a one-cycle lock strobe from an external lock model. It then drives `SYNC_FRAMES` frames whose data field is all zero, and only after that starts sending real words. If power-down is requested while the link is being driven, the block first holds the line high for `PULSE_BITS` bit times, which tells the far end to shut down, and then releases the driver. The parallel clock must already be running before power-down is released.

Top module: `sl_link_tx`

## Requirements
- R1: `din` is sampled at the clock edge that ends a cycle with `word_take` high, provided the link is in the data phase. That word is sent in the next frame at bit positions 1 to `DATA_W`, with `din[0]` first.
- R2: A frame is `DATA_W + 4` bits long. Bit position 0 is a guard bit that is always 0, and the final position is a 0 separator.
- R3: Bit positions `DATA_W + 1` and `DATA_W + 2` are both 1, and the line does not change level between them.
- R4: While the block is powered down or waiting for lock, `ser_oe` is 0 and `ser_o` is 0.
- R5: If `pwr_n` is low at an edge while the link is being driven, the block drives `ser_o` = 1 with `ser_oe` = 1 for exactly `PULSE_BITS` cycles, then powers down. The value of `pwr_n` during this pulse is ignored.
- R6: After `pwr_n` goes high, `ser_oe` stays 0 until an edge at which `lock_done` is 1. That edge starts the first frame. A `lock_done` strobe while powered down is ignored.
- R7: The first `SYNC_FRAMES` frames after lock carry an all-zero data field and `data_ready` = 0. From the frame after those onward, `data_ready` = 1.
- R8: While `rst_n` is low, and right after it is released, all outputs are 0 and the block is powered down.
- R9: If `pwr_n` goes low while the block is waiting for lock, it powers down at once, with no remote power-down pulse.
- R10: `word_take` is 1 exactly during the last bit time of every frame that is driven, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Power control, low = power down |
| lock_done | input | 1 | One-cycle lock strobe from the external lock model |
| din | input | DATA_W | Parallel data word |
| ser_o | output | 1 | Serial data |
| ser_oe | output | 1 | Serial driver enable |
| data_ready | output | 1 | High once real data is being sent |
| word_take | output | 1 | Parallel clock strobe, marks the last bit of a frame |

## Verification
The assertions check on every cycle that the line is disabled in the off and lock-wait states, that the guard bit is zero, that the overhead pair is high and stable, that the data field is zero during synchronization, that the remote power-down pulse is high and driven, and that the driver only turns on after a lock strobe. What only the bench scenarios can show is the exact sequence. That covers which word lands in which frame, the count of synchronization frames and pulse cycles, that lock strobes given while powered down are ignored, and that the block skips the pulse when power is dropped during the lock wait.

// File: rtl/sl_link_tx_pkg.sv
package sl_link_tx_pkg;

  typedef enum logic [2:0] {
    PS_OFF   = 3'd0,
    PS_LOCK  = 3'd1,
    PS_SYNC  = 3'd2,
    PS_RUN   = 3'd3,
    PS_PULSE = 3'd4
  } pwr_state_e;

  // guard bit + data + two overhead bits + separator
  function automatic int frame_len(input int data_w);
    return data_w + 4;
  endfunction

endpackage

// File: rtl/sl_pwr_seq.sv
module sl_pwr_seq
  import sl_link_tx_pkg::*;
#(
  parameter int SYNC_FRAMES = 4096,
  parameter int PULSE_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_n,
  input  logic       lock_done,
  input  logic       last_bit,
  output pwr_state_e state_o,
  output logic       streaming,
  output logic       pulsing,
  output logic       load_data
);

  localparam int SW = $clog2(SYNC_FRAMES + 1);
  localparam int PW = $clog2(PULSE_BITS + 1);
  localparam logic [SW-1:0] SYNC_LAST  = SW'(SYNC_FRAMES - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_BITS - 1);

  pwr_state_e    state_q, state_d;
  logic [SW-1:0] sync_q, sync_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          sync_done;

  assign sync_done = (sync_q == SYNC_LAST);

  always_comb begin
    state_d = state_q;
    sync_d  = sync_q;
    pcnt_d  = pcnt_q;
    case (state_q)
      PS_OFF: begin
        if (pwr_n) state_d = PS_LOCK;
      end
      PS_LOCK: begin
        if (!pwr_n) begin
          state_d = PS_OFF;
        end else if (lock_done) begin
          state_d = PS_SYNC;
          sync_d  = '0;
        end
      end
      PS_SYNC, PS_RUN: begin
        if (!pwr_n) begin
          state_d = PS_PULSE;
          pcnt_d  = '0;
        end else if (last_bit && state_q == PS_SYNC) begin
          if (sync_done) state_d = PS_RUN;
          else           sync_d  = sync_q + SW'(1);
        end
      end
      PS_PULSE: begin
        if (pcnt_q == PULSE_LAST) state_d = PS_OFF;
        else                      pcnt_d  = pcnt_q + PW'(1);
      end
      default: state_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      sync_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      sync_q  <= sync_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign state_o   = state_q;
  assign streaming = pwr_n && (state_q == PS_SYNC || state_q == PS_RUN) ? 1'b1
                   : (state_q == PS_SYNC || state_q == PS_RUN);
  assign pulsing   = (state_q == PS_PULSE);
  assign load_data = (state_q == PS_RUN) || (state_q == PS_SYNC && sync_done);

endmodule

// File: rtl/sl_frame_gen.sv
module sl_frame_gen
  import sl_link_tx_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              streaming,
  input  logic              pulsing,
  input  logic              load_data,
  input  logic [DATA_W-1:0] din,
  output logic              ser_o,
  output logic              last_bit,
  output logic [$clog2(DATA_W+4)-1:0] bit_cnt
);

  localparam int FL = frame_len(DATA_W);
  localparam int CW = $clog2(FL);
  localparam logic [CW-1:0] POS_LAST = CW'(FL - 1);
  localparam logic [CW-1:0] POS_OH0  = CW'(DATA_W + 1);
  localparam logic [CW-1:0] POS_OH1  = CW'(DATA_W + 2);
  localparam logic [CW-1:0] POS_DMAX = CW'(DATA_W);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] frm_q, frm_d;
  logic [CW-1:0]     idx;
  logic              line_bit;

  assign last_bit = streaming && (cnt_q == POS_LAST);

  always_comb begin
    cnt_d = cnt_q;
    frm_d = frm_q;
    if (!streaming) begin
      cnt_d = '0;
      frm_d = '0;
    end else if (cnt_q == POS_LAST) begin
      cnt_d = '0;
      frm_d = load_data ? din : '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      frm_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      frm_q <= frm_d;
    end
  end

  assign idx = cnt_q - CW'(1);

  always_comb begin
    if (cnt_q == '0)
      line_bit = 1'b0;
    else if (cnt_q <= POS_DMAX)
      line_bit = frm_q[idx];
    else if (cnt_q == POS_OH0 || cnt_q == POS_OH1)
      line_bit = 1'b1;
    else
      line_bit = 1'b0;
  end

  assign ser_o   = pulsing | (streaming & line_bit);
  assign bit_cnt = cnt_q;

endmodule

// File: rtl/sl_link_tx.sv
module sl_link_tx
  import sl_link_tx_pkg::*;
#(
  parameter int DATA_W      = 22,
  parameter int SYNC_FRAMES = 4096,
  parameter int PULSE_BITS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_n,
  input  logic              lock_done,
  input  logic [DATA_W-1:0] din,
  output logic              ser_o,
  output logic              ser_oe,
  output logic              data_ready,
  output logic              word_take
);

  localparam int CW = $clog2(frame_len(DATA_W));

  pwr_state_e    state_q;
  logic          streaming;
  logic          pulsing;
  logic          load_data;
  logic          last_bit;
  logic [CW-1:0] bit_cnt;

  sl_pwr_seq #(
    .SYNC_FRAMES(SYNC_FRAMES),
    .PULSE_BITS (PULSE_BITS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_n    (pwr_n),
    .lock_done(lock_done),
    .last_bit (last_bit),
    .state_o  (state_q),
    .streaming(streaming),
    .pulsing  (pulsing),
    .load_data(load_data)
  );

  sl_frame_gen #(
    .DATA_W(DATA_W)
  ) u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .streaming(streaming),
    .pulsing  (pulsing),
    .load_data(load_data),
    .din      (din),
    .ser_o    (ser_o),
    .last_bit (last_bit),
    .bit_cnt  (bit_cnt)
  );

  assign ser_oe     = streaming | pulsing;
  assign data_ready = (state_q == PS_RUN);
  assign word_take  = last_bit;

endmodule

// File: rtl/sl_link_tx_chk.sv
module sl_link_tx_chk
  import sl_link_tx_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_n,
  input logic       lock_done,
  input logic       ser_o,
  input logic       ser_oe,
  input logic       data_ready,
  input pwr_state_e state,
  input logic [$clog2(DATA_W+4)-1:0] bit_cnt
);

  localparam int CW = $clog2(DATA_W + 4);

  // R4
  assert_off_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_OFF || state == PS_LOCK) |-> (!ser_oe && !ser_o));

  // R5
  assert_pulse_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_PULSE) |-> (ser_oe && ser_o));

  // R2
  assert_guard_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_SYNC || state == PS_RUN) && bit_cnt == '0) |-> !ser_o);

  // R3
  assert_overhead_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_SYNC || state == PS_RUN) && bit_cnt == CW'(DATA_W + 2))
      |-> (ser_o && $stable(ser_o)));

  // R6
  assert_lock_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_oe) |-> ($past(lock_done) && $past(pwr_n)));

  // R7
  assert_sync_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SYNC && bit_cnt != '0 && bit_cnt <= CW'(DATA_W)) |-> !ser_o);

  // R7
  assert_ready_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> ser_oe);

endmodule

bind sl_link_tx sl_link_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_n     (pwr_n),
  .lock_done (lock_done),
  .ser_o     (ser_o),
  .ser_oe    (ser_oe),
  .data_ready(data_ready),
  .state     (state_q),
  .bit_cnt   (bit_cnt)
);

// File: tb/sim_sl_link_tx.sv
module sim_sl_link_tx;

  localparam int DW    = 22;
  localparam int SYNCF = 6;
  localparam int PB    = 8;
  localparam int FL    = DW + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pwr_n;
  logic          lock_done;
  logic [DW-1:0] din;
  logic          ser_o, ser_oe, data_ready, word_take;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model: 0 off, 1 lock wait, 2 sync, 3 run, 4 pulse
  int ms = 0;
  bit mq[$];
  int msync = 0;
  int mpulse = 0;

  always #4 clk = ~clk;

  sl_link_tx #(.DATA_W(DW), .SYNC_FRAMES(SYNCF), .PULSE_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .lock_done(lock_done), .din(din),
    .ser_o(ser_o), .ser_oe(ser_oe), .data_ready(data_ready), .word_take(word_take)
  );

  function automatic void push_frame(input logic [DW-1:0] w);
    mq.push_back(1'b0);
    for (int i = 0; i < DW; i++) mq.push_back(w[i]);
    mq.push_back(1'b1);
    mq.push_back(1'b1);
    mq.push_back(1'b0);
  endfunction

  function automatic void mstep(input logic p, input logic l, input logic [DW-1:0] d);
    case (ms)
      0: if (p) ms = 1;
      1: begin
        if (!p) ms = 0;
        else if (l) begin
          ms = 2; msync = 0; mq.delete(); push_frame('0);
        end
      end
      2, 3: begin
        if (!p) begin
          ms = 4; mpulse = PB; mq.delete();
        end else if (mq.size() == 1) begin
          mq.delete();
          if (ms == 2) begin
            msync++;
            if (msync == SYNCF) ms = 3;
          end
          push_frame(ms == 3 ? d : '0);
        end else begin
          void'(mq.pop_front());
        end
      end
      default: begin
        mpulse--;
        if (mpulse == 0) ms = 0;
      end
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic e_oe, e_ser, e_rdy, e_take;
    string tag;
    int pos;
    e_oe   = (ms >= 2);
    e_rdy  = (ms == 3);
    e_take = ((ms == 2 || ms == 3) && mq.size() == 1);
    pos    = FL - mq.size();
    if (ms == 4) begin
      e_ser = 1'b1; tag = "R5";
    end else if (ms == 2 || ms == 3) begin
      e_ser = mq[0];
      if (pos == 0 || pos == FL - 1) tag = "R2";
      else if (pos > DW)             tag = "R3";
      else if (ms == 2)              tag = "R7";
      else                           tag = "R1";
    end else begin
      e_ser = 1'b0; tag = (ms == 0) ? "R4" : "R9";
    end
    chk(ser_o, e_ser, tag, "ser_o");
    chk(ser_oe, e_oe, (ms == 1) ? "R6" : (ms == 4 ? "R5" : "R4"), "ser_oe");
    chk(data_ready, e_rdy, "R7", "data_ready");
    chk(word_take, e_take, "R10", "word_take");
  endtask

  task automatic cyc(input logic p, input logic l, input logic [DW-1:0] d);
    pwr_n = p; lock_done = l; din = d;
    mstep(p, l, d);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic run_rand(input logic p, input int n);
    for (int i = 0; i < n; i++) cyc(p, 1'b0, DW'($urandom));
  endtask

  initial begin
    rst_n = 1'b0; pwr_n = 1'b0; lock_done = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    // R8: outputs low in reset
    chk(ser_o, 1'b0, "R8", "ser_o in reset");
    chk(ser_oe, 1'b0, "R8", "ser_oe in reset");
    chk(data_ready, 1'b0, "R8", "data_ready in reset");
    chk(word_take, 1'b0, "R8", "word_take in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R6: lock strobe while powered down is ignored
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, '1);
    // power up, lock after a wait
    run_rand(1'b1, 5);
    cyc(1'b1, 1'b1, '1);
    // sync window then data, several patterns
    run_rand(1'b1, (SYNCF + 2) * FL);
    for (int i = 0; i < FL; i++) cyc(1'b1, 1'b0, '1);
    for (int i = 0; i < FL; i++) cyc(1'b1, 1'b0, DW'(22'h2AAAAA));
    run_rand(1'b1, 11);
    // R5: drop power mid-frame, try to re-release during the pulse
    cyc(1'b0, 1'b0, '0);
    cyc(1'b1, 1'b0, '0);
    run_rand(1'b0, PB + 3);

    // R9: drop power while waiting for lock
    run_rand(1'b1, 4);
    run_rand(1'b0, 3);

    // second link-up, drop during the sync window
    run_rand(1'b1, 2);
    cyc(1'b1, 1'b1, '0);
    run_rand(1'b1, FL * 2 + 5);
    run_rand(1'b0, PB + 2);

    // third link-up, lock immediately, drop on an overhead bit
    run_rand(1'b1, 1);
    cyc(1'b1, 1'b1, '0);
    run_rand(1'b1, (SYNCF + 3) * FL + DW + 1);
    run_rand(1'b0, PB + 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule